// File: doc/BRIEF.md
# Load Result Aligner and Extender

This unit sits between the read port of a 64-bit data memory and the register writeback path. Each request carries three things: the doubleword returned by the memory, the three low address bits of the access, and a 3-bit load code. The unit picks out the addressed byte, halfword, word or doubleword from the doubleword, using little-endian lane order. It then widens the value to 64 bits, with sign fill or zero fill as the load code asks. It also flags an access that is not naturally aligned, and it flags the one load code that is not defined.

Each accepted request yields one registered result. The result is offered on a valid/ready output. The input is accepted when the output register is empty, or when the output register is being drained in the same cycle. A consumer that stalls sees the result, and its flags, held unchanged until it takes them.

Top module: `load_extract`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it rises, `out_valid` is 0.
- R2: Little-endian lane order: the byte at address offset k (k = `addr_lo`) is `rdata[8k+7:8k]`, and it becomes bits 7:0 of the result. Wider loads take the bytes that follow, in ascending order, as ascending significance.
- R3: Load codes 3'b000 (byte), 3'b001 (half) and 3'b010 (word) are signed. Every result bit above the loaded width equals the top bit of the loaded value.
- R4: Load codes 3'b100 (byte), 3'b101 (half) and 3'b110 (word) are unsigned. Every result bit above the loaded width is 0.
- R5: Load code 3'b011 loads a doubleword. With `addr_lo` = 0 the result equals `rdata` unchanged.
- R6: An access is misaligned when it is a half with `addr_lo[0]`=1, a word with `addr_lo[1:0]`≠0, or a doubleword with `addr_lo`≠0. A misaligned access gives `out_misalign`=1 and `out_data`=0. A byte access is never misaligned.
- R7: Load code 3'b111 gives `out_illegal`=1, `out_misalign`=0 and `out_data`=0.
- R8: `in_ready` = !`out_valid` || `out_ready`. A request accepted at a clock edge (`in_valid` && `in_ready`) is presented with `out_valid`=1 after that edge. A result taken without a new acceptance clears `out_valid`.
- R9: While `out_valid`=1 and `out_ready`=0, `out_data`, `out_misalign` and `out_illegal` stay unchanged and `out_valid` stays 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Request present |
| in_ready | output | 1 | Request can be taken this cycle |
| rdata | input | 64 | Doubleword from memory |
| addr_lo | input | 3 | Byte offset within the doubleword |
| ltype | input | 3 | Load code |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes the result |
| out_data | output | 64 | Extended load result |
| out_misalign | output | 1 | Access was not naturally aligned |
| out_illegal | output | 1 | Load code 3'b111 was used |

## Verification
The bound checker watches several rules on every cycle. It checks that a stalled result and its flags hold still, that `in_ready` drops under a stall, and that an accepted request shows up one cycle later. It also checks the upper-bit fill of signed bytes and unsigned halves, that a misaligned doubleword is flagged, and that an illegal code gives a zero result. Exact lane selection at every offset, for all eight codes, can only be shown by the bench's scenarios. The same goes for one result per request under random stalls, and for back-to-back accept-while-drain cycles. There, a behavioural model predicts each output cycle by cycle.

// File: rtl/load_extract.sv
module load_extract #(
  parameter int DW = 64
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [DW-1:0] rdata,
  input  logic [2:0]    addr_lo,
  input  logic [2:0]    ltype,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [DW-1:0] out_data,
  output logic          out_misalign,
  output logic          out_illegal
);
  localparam int SHW = $clog2(DW);

  logic [1:0]    sz;
  logic          uns, bad_code, mis;
  logic [DW-1:0] lane, ext;
  logic [SHW-1:0] shamt;

  assign sz       = ltype[1:0];
  assign uns      = ltype[2];
  assign bad_code = &ltype;
  assign shamt    = SHW'({addr_lo, 3'b000});
  assign lane     = rdata >> shamt;
  assign in_ready = !out_valid || out_ready;

  always_comb begin
    case (sz)
      2'd0:    mis = 1'b0;
      2'd1:    mis = addr_lo[0];
      2'd2:    mis = |addr_lo[1:0];
      default: mis = |addr_lo;
    endcase
    if (bad_code) mis = 1'b0;
  end

  always_comb begin
    case (sz)
      2'd0:    ext = {{(DW-8){!uns && lane[7]}},   lane[7:0]};
      2'd1:    ext = {{(DW-16){!uns && lane[15]}}, lane[15:0]};
      2'd2:    ext = {{(DW-32){!uns && lane[31]}}, lane[31:0]};
      default: ext = lane;
    endcase
    if (mis || bad_code) ext = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid    <= 1'b0;
      out_data     <= '0;
      out_misalign <= 1'b0;
      out_illegal  <= 1'b0;
    end else if (in_valid && in_ready) begin
      out_valid    <= 1'b1;
      out_data     <= ext;
      out_misalign <= mis;
      out_illegal  <= bad_code;
    end else if (out_ready) begin
      out_valid    <= 1'b0;
    end
  end
endmodule

module load_extract_chk #(
  parameter int DW = 64
) (
  input logic          clk,
  input logic          rst_n,
  input logic          in_valid,
  input logic          in_ready,
  input logic [2:0]    addr_lo,
  input logic [2:0]    ltype,
  input logic          out_valid,
  input logic          out_ready,
  input logic [DW-1:0] out_data,
  input logic          out_misalign,
  input logic          out_illegal
);
  logic acc;
  assign acc = in_valid && in_ready;

  p_reset_idle_r1: assert property (@(posedge clk) !rst_n |=> !out_valid);

  p_sext_byte_r3: assert property (@(posedge clk) disable iff (!rst_n)
    acc && ltype == 3'b000 |=> out_data[DW-1:8] == {(DW-8){out_data[7]}});

  p_zext_half_r4: assert property (@(posedge clk) disable iff (!rst_n)
    acc && ltype == 3'b101 |=> out_data[DW-1:16] == '0);

  p_dword_mis_r6: assert property (@(posedge clk) disable iff (!rst_n)
    acc && ltype == 3'b011 && addr_lo != 3'd0 |=> out_misalign && out_data == '0);

  p_bad_code_r7: assert property (@(posedge clk) disable iff (!rst_n)
    acc && ltype == 3'b111 |=> out_illegal && !out_misalign && out_data == '0);

  p_accept_r8: assert property (@(posedge clk) disable iff (!rst_n)
    acc |=> out_valid);

  p_stall_block_r8: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |-> !in_ready);

  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data)
      && $stable(out_misalign) && $stable(out_illegal));
endmodule

bind load_extract load_extract_chk #(.DW(DW)) u_load_extract_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .addr_lo(addr_lo), .ltype(ltype), .out_valid(out_valid),
  .out_ready(out_ready), .out_data(out_data),
  .out_misalign(out_misalign), .out_illegal(out_illegal));

// File: tb/test_load_extract.sv
module test_load_extract;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [63:0] rdata = '0;
  logic [2:0]  addr_lo = '0;
  logic [2:0]  ltype = '0;
  logic        out_valid;
  logic        out_ready = 1'b0;
  logic [63:0] out_data;
  logic        out_misalign;
  logic        out_illegal;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  logic        m_valid = 0;
  logic [63:0] m_data = '0;
  logic        m_mis = 0, m_ill = 0;
  string       m_tag = "R1";
  bit          prev_stall = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  load_extract i_load_extract (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .rdata(rdata), .addr_lo(addr_lo), .ltype(ltype),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
    .out_misalign(out_misalign), .out_illegal(out_illegal));

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic ref_load(input logic [63:0] d, input int a, input int code,
                          output logic [63:0] r, output logic mis,
                          output logic ill, output string tag);
    int nb;
    r = '0; mis = 0; ill = 0;
    if (code == 7) begin ill = 1; tag = "R7"; return; end
    nb = 1 << (code % 4);
    if (a % nb != 0) begin mis = 1; tag = "R6"; return; end
    for (int i = 0; i < nb; i++) r[8*i +: 8] = d[8*(a+i) +: 8];
    if (code < 4 && nb < 8 && r[8*nb-1])
      for (int b = 8*nb; b < 64; b++) r[b] = 1'b1;
    if (nb == 8) tag = "R5";
    else if (code >= 4) tag = "R4";
    else if (a != 0) tag = "R2";
    else tag = "R3";
  endtask

  task automatic cycle(input bit v, input logic [63:0] d, input int a,
                       input int code, input bit rdy);
    logic [63:0] r; logic mis, ill; string tag; bit acc;
    @(negedge clk);
    chk("R8", {63'b0, out_valid}, {63'b0, m_valid});
    if (m_valid) begin
      chk(m_tag, out_data, m_data);
      chk(m_tag, {62'b0, out_misalign, out_illegal}, {62'b0, m_mis, m_ill});
      if (prev_stall) chk("R9", out_data, m_data);
    end
    in_valid = v; rdata = d; addr_lo = 3'(a); ltype = 3'(code); out_ready = rdy;
    #1;
    chk("R8", {63'b0, in_ready}, {63'b0, !m_valid || rdy});
    acc = v && (!m_valid || rdy);
    prev_stall = m_valid && !rdy;
    if (acc) begin
      ref_load(d, a, code, r, mis, ill, tag);
      m_valid = 1; m_data = r; m_mis = mis; m_ill = ill; m_tag = tag;
    end else if (rdy) m_valid = 0;
  endtask

  function automatic logic [63:0] rnd64();
    return {$urandom, $urandom};
  endfunction

  initial begin
    repeat (3) begin
      @(negedge clk);
      chk("R1", {63'b0, out_valid}, 64'd0);
    end
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", {63'b0, out_valid}, 64'd0);
    // every code at every offset, consumer always ready
    for (int c = 0; c < 8; c++)
      for (int a = 0; a < 8; a++)
        cycle(1, rnd64(), a, c, 1);
    // sign-bit corners: all-ones and alternating patterns
    for (int c = 0; c < 8; c++) begin
      cycle(1, 64'hFFFF_FFFF_FFFF_FFFF, 0, c, 1);
      cycle(1, 64'h7F80_7FFF_8000_7F80, 0, c, 1);
      cycle(1, 64'h8000_0000_8000_0080, 4, c, 1);
    end
    // long stall then drain
    cycle(1, 64'h0123_4567_89AB_CDEF, 2, 1, 0);
    repeat (4) cycle(1, rnd64(), 0, 3, 0);
    cycle(0, '0, 0, 0, 1);
    cycle(0, '0, 0, 0, 1);
    // random traffic with random back-pressure
    repeat (600)
      cycle(($urandom % 4) != 0, rnd64(), int'($urandom % 8), int'($urandom % 8),
            ($urandom % 3) != 0);
    cycle(0, '0, 0, 0, 1);
    cycle(0, '0, 0, 0, 1);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule